// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Mode Core

This block is a cycle-based behavioural model of an ultraviolet-erasable, byte-wide programmable memory. It watches an active-low chip-select/program strobe, an active-low output-enable and two flags that stand in for the high-voltage pins: `vpp_hi` for the raised programming supply and `id_hi` for the raised signature voltage on address bit 9. From these it picks one of eight operating modes: read, output-off, standby, program, verify, inhibit, signature, and busy while an erase runs. The data bus is split into `data_in`, `data_out` and a drive enable `data_oe`.

Programming is one-way. A write can only clear bits, and the stored byte becomes the old byte ANDed with the presented data. A write is committed only when a low pulse on `ce_n` ends, taken under program conditions, and only if that pulse lasted at least `MIN_PULSE` clock cycles. A strobe that is simply held low never counts as a pulse. The `erase` input starts a sweep that writes 0xFF into every location, one per cycle. Reset runs the same sweep, so the array always starts blank. The array holds `2**ADDR_W` bytes. `ADDR_W = 15` gives the full 32768-byte part, and the default is reduced to keep elaboration small.

The sequencer has four named states. `S_SWEEP` writes 0xFF at one address per cycle. `S_WAIT_HI` waits for the strobe to return high. `S_IDLE` has the strobe high and is ready for a pulse. `S_LOW` counts an accepted program pulse.

The transitions are:
- Reset leads to `S_SWEEP`.
- `S_SWEEP` goes to `S_WAIT_HI` after the last address.
- `erase` takes any other state to `S_SWEEP`.
- `S_WAIT_HI` goes to `S_IDLE` when `ce_n` is high.
- `S_IDLE` goes to `S_LOW` when program conditions are present.
- `S_IDLE` goes to `S_WAIT_HI` when `ce_n` is low outside program conditions.
- `S_LOW` goes to `S_IDLE` when `ce_n` rises. This is the commit or the short-pulse report.
- `S_LOW` goes to `S_WAIT_HI` when the conditions drop while the strobe is still low. This is an abort.

Top module: `otp_mem_core`

## Requirements
- R1: Reset starts an erase sweep. Once it ends, every location reads 0xFF.
- R2: When `vpp_hi`=0, `id_hi`=0, `ce_n`=0 and `oe_n`=0, `data_oe`=1 and `data_out` is the byte at `addr`. Outputs are combinational from the current inputs.
- R3: When `vpp_hi`=0 and `id_hi`=0, `ce_n`=1 gives `data_oe`=0 whatever `oe_n` is, and `oe_n`=1 gives `data_oe`=0. `data_out` is 0 whenever `data_oe` is 0.
- R4: Program mode is `vpp_hi`=1, `id_hi`=0, `ce_n`=0, `oe_n`=1. A pulse is counted only if it starts with `ce_n` falling from high while these conditions hold. At the clock edge where `ce_n` is first seen high again, the byte at the address last sampled during the pulse becomes old AND data. The new value is readable in the next cycle.
- R5: A program operation never turns a 0 bit into a 1. Data bits of 1 leave the stored bits unchanged. Only the erase sweep returns bits to 1.
- R6: Verify mode is `vpp_hi`=1, `ce_n`=1, `oe_n`=0 with `id_hi`=0. It drives the stored byte with `data_oe`=1.
- R7: With `vpp_hi`=1 and `id_hi`=0, `ce_n`=`oe_n`=1 (inhibit) or `ce_n`=`oe_n`=0 gives `data_oe`=0 and writes nothing.
- R8: Holding `ce_n` low while program conditions appear does not program. A pulse whose conditions drop before `ce_n` rises is aborted with no write and no short flag.
- R9: A pulse that sees fewer than `MIN_PULSE` (default 4) low clock edges writes nothing, and raises `short_pulse` for exactly one cycle after the release edge. A pulse of exactly `MIN_PULSE` edges is committed.
- R10: When `id_hi`=1, `ce_n`=0 and `oe_n`=0, the block drives 0x8F if `addr[0]`=0 and 0x04 if `addr[0]`=1. With `id_hi`=1 and any other control setting, `data_oe`=0.
- R11: A program pulse with `id_hi`=1 writes nothing.
- R12: An `erase` high sampled outside a sweep starts a sweep of exactly `2**ADDR_W` cycles. During the sweep `erase_busy`=1, `data_oe`=0 and a pulse in progress is dropped. Afterwards every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts an erase sweep |
| ce_n | input | 1 | Active-low chip select and program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply raised |
| id_hi | input | 1 | Signature voltage on address bit 9 present |
| erase | input | 1 | Request a full-array erase |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Program data |
| data_out | output | 8 | Read data, 0 when not driven |
| data_oe | output | 1 | Data bus drive enable |
| short_pulse | output | 1 | One-cycle flag for a rejected short pulse |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
Several properties are checked on every cycle:
- The bus stays undriven in standby, inhibit and busy.
- The signature bytes follow `addr[0]`.
- The short flag never lasts longer than one cycle.
- No write strobe fires while the signature flag is up.
- A byte read twice in a row at the same address never gains a 1 bit.

Only the bench's scenarios can show the following:
- The exact AND result of a program operation.
- The pulse-length boundary at `MIN_PULSE`.
- That a level held low or an aborted pulse leaves the array untouched.
- The sweep length, and the blank array after an erase.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;
    localparam int OTP_DW = 8;
    localparam logic [OTP_DW-1:0] MAKER_CODE  = 8'h8F;
    localparam logic [OTP_DW-1:0] DEVICE_CODE = 8'h04;
    localparam logic [OTP_DW-1:0] BLANK_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        MODE_READ,
        MODE_ODIS,
        MODE_STBY,
        MODE_PROG,
        MODE_VERIFY,
        MODE_INHIBIT,
        MODE_ID,
        MODE_BUSY
    } otp_mode_e;

    typedef enum logic [1:0] {
        S_SWEEP,
        S_WAIT_HI,
        S_IDLE,
        S_LOW
    } otp_state_e;
endpackage

// File: rtl/otp_mode_decode.sv
`timescale 1ns/1ps
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_hi,
    input  logic      id_hi,
    input  logic      busy,
    output otp_mode_e mode
);
    always_comb begin
        if (busy) begin
            mode = MODE_BUSY;
        end else if (id_hi) begin
            if (!ce_n && !oe_n) mode = MODE_ID;
            else if (ce_n)      mode = MODE_STBY;
            else                mode = MODE_ODIS;
        end else if (!vpp_hi) begin
            if (ce_n)      mode = MODE_STBY;
            else if (oe_n) mode = MODE_ODIS;
            else           mode = MODE_READ;
        end else begin
            unique case ({ce_n, oe_n})
                2'b01:   mode = MODE_PROG;
                2'b10:   mode = MODE_VERIFY;
                2'b11:   mode = MODE_INHIBIT;
                default: mode = MODE_ODIS;
            endcase
        end
    end
endmodule

// File: rtl/otp_cell_array.sv
`timescale 1ns/1ps
module otp_cell_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              sweep_we,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [OTP_DW-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [OTP_DW-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [OTP_DW-1:0] cells [DEPTH];

    // Sweep has priority; program can only clear bits.
    always_ff @(posedge clk) begin
        if (sweep_we) begin
            cells[sweep_addr] <= BLANK_BYTE;
        end else if (prog_we) begin
            cells[prog_addr] <= cells[prog_addr] & prog_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/otp_seq.sv
`timescale 1ns/1ps
module otp_seq
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              erase,
    input  otp_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OTP_DW-1:0] data_in,
    output logic              prog_we,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [OTP_DW-1:0] prog_data,
    output logic              sweep_we,
    output logic [ADDR_W-1:0] sweep_addr,
    output logic              busy,
    output logic              short_pulse
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [CNT_W-1:0]  CNT_MIN   = CNT_W'(MIN_PULSE);

    otp_state_e        state, nstate;
    logic [CNT_W-1:0]  pulse_cnt;
    logic [ADDR_W-1:0] lat_addr;
    logic [OTP_DW-1:0] lat_data;
    logic [ADDR_W-1:0] sweep_cnt;
    logic              short_q;
    logic              release_edge;
    logic              long_enough;

    assign release_edge = (state == S_LOW) && ce_n && !erase;
    assign long_enough  = (pulse_cnt >= CNT_MIN);

    always_comb begin
        nstate = state;
        unique case (state)
            S_SWEEP: begin
                if (sweep_cnt == LAST_ADDR) nstate = S_WAIT_HI;
            end
            S_WAIT_HI: begin
                if (erase)     nstate = S_SWEEP;
                else if (ce_n) nstate = S_IDLE;
            end
            S_IDLE: begin
                if (erase)                  nstate = S_SWEEP;
                else if (mode == MODE_PROG) nstate = S_LOW;
                else if (!ce_n)             nstate = S_WAIT_HI;
            end
            S_LOW: begin
                if (erase)                  nstate = S_SWEEP;
                else if (ce_n)              nstate = S_IDLE;
                else if (mode != MODE_PROG) nstate = S_WAIT_HI;
            end
            default: nstate = S_WAIT_HI;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_SWEEP;
        else        state <= nstate;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
            lat_addr  <= '0;
            lat_data  <= '0;
            sweep_cnt <= '0;
            short_q   <= 1'b0;
        end else begin
            short_q <= release_edge && !long_enough;
            if (state == S_SWEEP)     sweep_cnt <= sweep_cnt + ADDR_W'(1);
            else if (nstate == S_SWEEP) sweep_cnt <= '0;
            if (state == S_IDLE && nstate == S_LOW) begin
                pulse_cnt <= CNT_W'(1);
                lat_addr  <= addr;
                lat_data  <= data_in;
            end else if (state == S_LOW && nstate == S_LOW) begin
                if (!long_enough) pulse_cnt <= pulse_cnt + CNT_W'(1);
                lat_addr <= addr;
                lat_data <= data_in;
            end
        end
    end

    // Outputs
    always_comb begin
        prog_we     = release_edge && long_enough;
        prog_addr   = lat_addr;
        prog_data   = lat_data;
        sweep_we    = (state == S_SWEEP);
        sweep_addr  = sweep_cnt;
        busy        = (state == S_SWEEP);
        short_pulse = short_q;
    end
endmodule

// File: rtl/otp_mem_core.sv
`timescale 1ns/1ps
module otp_mem_core
    import otp_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hi,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic              short_pulse,
    output logic              erase_busy
);
    otp_mode_e         mode;
    logic              busy;
    logic              prog_we;
    logic [ADDR_W-1:0] prog_addr;
    logic [OTP_DW-1:0] prog_data;
    logic              sweep_we;
    logic [ADDR_W-1:0] sweep_addr;
    logic [OTP_DW-1:0] rd_data;

    otp_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_hi  (id_hi),
        .busy   (busy),
        .mode   (mode)
    );

    otp_seq #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .erase       (erase),
        .mode        (mode),
        .addr        (addr),
        .data_in     (data_in),
        .prog_we     (prog_we),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .sweep_we    (sweep_we),
        .sweep_addr  (sweep_addr),
        .busy        (busy),
        .short_pulse (short_pulse)
    );

    otp_cell_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk        (clk),
        .sweep_we   (sweep_we),
        .sweep_addr (sweep_addr),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .rd_addr    (addr),
        .rd_data    (rd_data)
    );

    assign erase_busy = busy;

    always_comb begin
        data_oe  = 1'b0;
        data_out = '0;
        unique case (mode)
            MODE_READ, MODE_VERIFY: begin
                data_oe  = 1'b1;
                data_out = rd_data;
            end
            MODE_ID: begin
                data_oe  = 1'b1;
                data_out = addr[0] ? DEVICE_CODE : MAKER_CODE;
            end
            default: begin
                data_oe  = 1'b0;
                data_out = '0;
            end
        endcase
    end
endmodule

// File: rtl/otp_mem_core_chk.sv
`timescale 1ns/1ps
module otp_mem_core_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              id_hi,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        data_out,
    input logic              data_oe,
    input logic              short_pulse,
    input logic              erase_busy,
    input logic              prog_we
);
    logic rd_cond;
    assign rd_cond = !ce_n && !oe_n && !vpp_hi && !id_hi && !erase_busy;

    a_r3_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |-> !data_oe);

    a_r7_inhibit_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && oe_n && vpp_hi) |-> !data_oe);

    a_r12_busy_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> (!data_oe && !prog_we));

    a_r10_sig_code: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hi && !ce_n && !oe_n && !erase_busy) |->
        (data_oe && data_out == (addr[0] ? 8'h04 : 8'h8F)));

    a_r11_no_sig_write: assert property (@(posedge clk) disable iff (!rst_n)
        id_hi |-> !prog_we);

    a_r9_short_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        short_pulse |=> !short_pulse);

    a_r5_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cond && $past(rd_cond) && addr == $past(addr)) |->
        ((data_out & ~$past(data_out)) == 8'h00));
endmodule

bind otp_mem_core otp_mem_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .vpp_hi      (vpp_hi),
    .id_hi       (id_hi),
    .addr        (addr),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .short_pulse (short_pulse),
    .erase_busy  (erase_busy),
    .prog_we     (prog_we)
);

// File: tb/tb_otp_mem_core.sv
`timescale 1ns/1ps
module tb_otp_mem_core;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int MINP  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data_in = '0;
    logic [7:0]    data_out;
    logic          data_oe, short_pulse, erase_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    otp_mem_core #(.ADDR_W(AW), .MIN_PULSE(MINP)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .id_hi(id_hi), .erase(erase), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .short_pulse(short_pulse),
        .erase_busy(erase_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hi = 1'b0; erase = 1'b0;
    endtask

    task automatic read_byte(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        vpp_hi = 1'b0; id_hi = 1'b0; addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #2; v = data_out; oe = data_oe;
    endtask

    task automatic expect_byte(input string tag, input logic [AW-1:0] a, input logic [7:0] e);
        logic [7:0] v; logic oe;
        read_byte(a, v, oe);
        chk(tag, {23'd0, oe, v}, {23'd0, 1'b1, e});
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                         input logic sig, output logic sh);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b1; id_hi = sig; addr = a; data_in = d;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (n) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        sh = short_pulse;
        data_in = 8'h00; vpp_hi = 1'b0; id_hi = 1'b0;
    endtask

    task automatic count_busy(output int c);
        c = 0;
        while (erase_busy && c < DEPTH + 10) begin
            c++;
            @(negedge clk);
        end
    endtask

    // R1, R12: reset sweep
    task automatic t_reset();
        int c;
        @(negedge clk);
        rst_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        #2;
        chk("R12 reset busy", {31'd0, erase_busy}, 32'd1);
        chk("R12 reset hiz", {31'd0, data_oe}, 32'd0);
        #1;
        count_busy(c);
        chk("R12 reset sweep length", c, DEPTH);
        go_idle();
        expect_byte("R1 blank addr 0", '0, 8'hFF);
        expect_byte("R1 blank addr top", '1, 8'hFF);
        expect_byte("R1 blank addr mid", 10'h155, 8'hFF);
    endtask

    // R3
    task automatic t_hiz();
        @(negedge clk);
        vpp_hi = 1'b0; id_hi = 1'b0; ce_n = 1'b0; oe_n = 1'b1; #2;
        chk("R3 output off oe", {31'd0, data_oe}, 32'd0);
        chk("R3 output off data", data_out, 32'd0);
        ce_n = 1'b1; oe_n = 1'b0; #2;
        chk("R3 standby oe", {31'd0, data_oe}, 32'd0);
        chk("R3 standby data", data_out, 32'd0);
    endtask

    // R2, R4, R6, R5
    task automatic t_program();
        logic sh;
        go_idle();
        pulse(10'h012, 8'hA5, 6, 1'b0, sh);
        chk("R9 no short on long pulse", {31'd0, sh}, 32'd0);
        expect_byte("R4 R2 program A5", 10'h012, 8'hA5);
        @(negedge clk);
        vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b0; addr = 10'h012; #2;
        chk("R6 verify drives", {23'd0, data_oe, data_out}, {23'd0, 1'b1, 8'hA5});
        go_idle();
        pulse(10'h012, 8'h5A, 5, 1'b0, sh);
        expect_byte("R5 AND gives 00", 10'h012, 8'h00);
        go_idle();
        pulse(10'h012, 8'hFF, 5, 1'b0, sh);
        expect_byte("R5 ones cannot set", 10'h012, 8'h00);
        go_idle();
        pulse(10'h040, 8'h3C, 5, 1'b0, sh);
        go_idle();
        pulse(10'h040, 8'hFF, 5, 1'b0, sh);
        expect_byte("R5 FF leaves 3C", 10'h040, 8'h3C);
    endtask

    // R9
    task automatic t_short();
        logic sh;
        go_idle();
        pulse(10'h020, 8'h00, MINP - 1, 1'b0, sh);
        chk("R9 short flag", {31'd0, sh}, 32'd1);
        @(negedge clk);
        chk("R9 short one cycle", {31'd0, short_pulse}, 32'd0);
        expect_byte("R9 short no write", 10'h020, 8'hFF);
        go_idle();
        pulse(10'h020, 8'h81, MINP, 1'b0, sh);
        chk("R9 boundary no flag", {31'd0, sh}, 32'd0);
        expect_byte("R9 boundary written", 10'h020, 8'h81);
    endtask

    // R7
    task automatic t_inhibit();
        logic sh;
        go_idle();
        @(negedge clk);
        vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1; addr = 10'h060; data_in = 8'h00; #2;
        chk("R7 inhibit hiz", {31'd0, data_oe}, 32'd0);
        repeat (3) @(negedge clk);
        oe_n = 1'b0; ce_n = 1'b0; #2;
        chk("R7 both low hiz", {31'd0, data_oe}, 32'd0);
        repeat (6) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        sh = short_pulse;
        chk("R7 both low no flag", {31'd0, sh}, 32'd0);
        go_idle();
        expect_byte("R7 no write", 10'h060, 8'hFF);
    endtask

    // R8
    task automatic t_level();
        go_idle();
        @(negedge clk);
        addr = 10'h030; data_in = 8'h00; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        vpp_hi = 1'b1; oe_n = 1'b1;
        repeat (8) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        chk("R8 level no flag", {31'd0, short_pulse}, 32'd0);
        go_idle();
        expect_byte("R8 level no write", 10'h030, 8'hFF);
        go_idle();
        @(negedge clk);
        vpp_hi = 1'b1; addr = 10'h031; data_in = 8'h00;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        oe_n = 1'b1;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        chk("R8 abort no flag", {31'd0, short_pulse}, 32'd0);
        go_idle();
        expect_byte("R8 abort no write", 10'h031, 8'hFF);
    endtask

    // R10, R11
    task automatic t_sig();
        logic sh;
        go_idle();
        @(negedge clk);
        id_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = '0; #2;
        chk("R10 maker code", {23'd0, data_oe, data_out}, {23'd0, 1'b1, 8'h8F});
        addr = 10'h001; #2;
        chk("R10 device code", {23'd0, data_oe, data_out}, {23'd0, 1'b1, 8'h04});
        ce_n = 1'b1; #2;
        chk("R10 sig standby hiz", {31'd0, data_oe}, 32'd0);
        go_idle();
        pulse(10'h050, 8'h00, 6, 1'b1, sh);
        go_idle();
        expect_byte("R11 sig write ignored", 10'h050, 8'hFF);
    endtask

    // R12
    task automatic t_erase();
        int c;
        go_idle();
        @(negedge clk);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = 10'h040; #2;
        chk("R12 busy hiz", {23'd0, data_oe, data_out}, 32'd0);
        #1;
        count_busy(c);
        chk("R12 sweep length", c, DEPTH);
        go_idle();
        expect_byte("R12 erased 012", 10'h012, 8'hFF);
        expect_byte("R12 erased 040", 10'h040, 8'hFF);
        expect_byte("R12 erased 020", 10'h020, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_hiz();
        t_program();
        t_short();
        t_inhibit();
        t_level();
        t_sig();
        t_erase();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule